// File: doc/BRIEF.md
# Clock-Stop Handshake and Wakeup Controller

This block sits between a software register bus and a serial-bus protocol core and runs the core's low-power entry and exit. When software sets a stop bit, it asserts a clock-stop request to the core. The core finishes its traffic, sets its own init bit and raises an acknowledge. The controller synchronizes that acknowledge and uses a registered copy of it to drop two clock enables: one for the host-side clock and one for the core clock.

Wake-up has three forms. In the first, only software clearing the stop bit ends the stop. In the second, a falling edge on the receive line while the clocks are gated cancels the stop request. This is a hardware override, and it is recorded in a status bit and can raise an interrupt. The third form behaves like the second, and in addition, when the acknowledge falls after such a wake, the controller clears the core's init bit with a read-modify-write, so the core resumes without software help.

The whole block runs on one always-on register clock. The acknowledge and the receive line come in asynchronously and pass through two-flop synchronizers.

Top module: `clkstop_wake_ctrl`

## Requirements
- R1: A write to address 1 loads bit 0 into the stop bit, which drives `stop_req` from the next clock edge. The stop bit reads back at address 1, bit 0. After reset it is 0.
- R2: `hclk_en` and `cclk_en` are both low exactly while the acknowledge, delayed by three clock edges (two synchronizer stages and one register), is high. That same delayed acknowledge reads back as address 2, bit 0. After reset the enables are 1.
- R3: When wake enable (address 0, bit 0) is 0, receive-line activity never changes the stop bit, the override bit, the wake flag or `wake_irq`.
- R4: When wake enable is 1, a 1-to-0 edge on `rx_in` clears the stop bit and sets the override bit (address 2, bit 1) and the wake flag (address 2, bit 2). The edge only counts while the synchronized acknowledge is high and the stop bit is set. The change is visible 4 edges after the first edge that samples the low level.
- R5: Writing 1 to the stop bit clears the override bit.
- R6: `wake_irq` equals wake flag AND interrupt enable (address 0, bit 2). A wake with the interrupt enable at 0 sets the flag but leaves `wake_irq` low.
- R7: With auto-wake (address 0, bit 1) and wake enable both 1, a wake arms a pending clear. On the next fall of the delayed acknowledge, `cfg_we` pulses for exactly one cycle. During that pulse, `cfg_wdata` equals `cfg_rdata` with bit `INIT_BIT` forced to 0.
- R8: If a software write to the stop bit lands in the same cycle as a hardware wake, the wake wins. The stop bit ends at 0 and the override bit at 1.
- R9: A falling edge on `rx_in` while the clocks are not gated causes no wake.
- R10: Writing 1 to address 2, bit 2 clears the wake flag. Writing 0 to that bit leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| stop_ack | input | 1 | Clock-stop acknowledge from the core (asynchronous) |
| rx_in | input | 1 | Receive line, after any glitch filter (asynchronous) |
| cfg_rdata | input | CFG_W | Current value of the core's config register |
| stop_req | output | 1 | Clock-stop request to the core |
| hclk_en | output | 1 | Host clock enable |
| cclk_en | output | 1 | Core clock enable |
| wake_irq | output | 1 | Wake interrupt |
| cfg_we | output | 1 | Write strobe to the core's config register |
| cfg_wdata | output | CFG_W | Write data with the init bit cleared |

## Verification
The assertions check the following on every cycle:
- A detected wake always leaves the stop bit clear and the override bit set.
- The override bit only rises right after a wake pulse.
- A plain stop write clears the override bit.
- The init-clear strobe is a single cycle and appears only while the clocks are enabled.

Only the bench's scenarios can show the rest:
- The exact three-edge latency of the enables.
- Receive activity being ignored when wake is disabled or the clocks are running.
- The read-modify-write data carrying the other config bits through.
- The outcome of a stop write colliding with a wake.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STOP = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  // control register bits
  localparam int B_WAKE_EN = 0;
  localparam int B_AUTO    = 1;
  localparam int B_IRQ_EN  = 2;
  // status register bits
  localparam int B_ACK     = 0;
  localparam int B_OVR     = 1;
  localparam int B_FLAG    = 2;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;
  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end
  assign q = st[STAGES-1];
endmodule

// File: rtl/cs_wake_detect.sv
module cs_wake_detect (
  input  logic clk,
  input  logic rst,
  input  logic rx_s,
  input  logic ack_s,
  input  logic wake_en,
  input  logic stop_q,
  output logic wake_pulse
);
  logic rx_prev;
  logic fall;
  assign fall = rx_prev & ~rx_s & ack_s & wake_en & stop_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev    <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      rx_prev    <= rx_s;
      wake_pulse <= fall;
    end
  end
endmodule

// File: rtl/cs_regs.sv
module cs_regs
  import clkstop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wake_pulse,
  input  logic              ack_q,
  output logic              stop_q,
  output logic              wake_en,
  output logic              auto_wake,
  output logic              irq_en,
  output logic              hw_ovr,
  output logic              wake_flag
);
  logic wr_ctrl, wr_stop, wr_stat;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stop = wr_en && (wr_addr == A_STOP);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q    <= 1'b0;
      wake_en   <= 1'b0;
      auto_wake <= 1'b0;
      irq_en    <= 1'b0;
      hw_ovr    <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wake_en   <= wr_data[B_WAKE_EN];
        auto_wake <= wr_data[B_AUTO];
        irq_en    <= wr_data[B_IRQ_EN];
      end
      if (wake_pulse) begin
        // hardware override wins over any software write this cycle
        stop_q    <= 1'b0;
        hw_ovr    <= 1'b1;
        wake_flag <= 1'b1;
      end else begin
        if (wr_stop) begin
          stop_q <= wr_data[0];
          if (wr_data[0]) hw_ovr <= 1'b0;
        end
        if (wr_stat && wr_data[B_FLAG]) wake_flag <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_WAKE_EN] = wake_en;
        rd_data[B_AUTO]    = auto_wake;
        rd_data[B_IRQ_EN]  = irq_en;
      end
      A_STOP: rd_data[0] = stop_q;
      A_STAT: begin
        rd_data[B_ACK]  = ack_q;
        rd_data[B_OVR]  = hw_ovr;
        rd_data[B_FLAG] = wake_flag;
      end
      default: rd_data = '0;
    endcase
  end

  assert_wake_clears_stop_R4: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> (!stop_q && hw_ovr && wake_flag));
  assert_ovr_only_from_wake_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hw_ovr) |-> $past(wake_pulse));
  assert_stop_set_clears_ovr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stop && wr_data[0] && !wake_pulse) |=> (stop_q && !hw_ovr));
endmodule

// File: rtl/cs_init_clear.sv
module cs_init_clear #(
  parameter int CFG_W    = 8,
  parameter int INIT_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             ack_q,
  input  logic [CFG_W-1:0] cfg_rdata,
  output logic             cfg_we,
  output logic [CFG_W-1:0] cfg_wdata
);
  localparam logic [CFG_W-1:0] INIT_MASK = CFG_W'(1) << INIT_BIT;
  logic ack_prev, pending, fire;
  assign fire = pending && ack_prev && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_prev  <= 1'b0;
      pending   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_wdata <= '0;
    end else begin
      ack_prev <= ack_q;
      cfg_we   <= fire;
      if (fire) begin
        cfg_wdata <= cfg_rdata & ~INIT_MASK;
        pending   <= 1'b0;
      end
      if (arm) pending <= 1'b1;
    end
  end

  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !cfg_we);
endmodule

// File: rtl/clkstop_wake_ctrl.sv
module clkstop_wake_ctrl
  import clkstop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 8,
  parameter int INIT_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_ack,
  input  logic              rx_in,
  input  logic [CFG_W-1:0]  cfg_rdata,
  output logic              stop_req,
  output logic              hclk_en,
  output logic              cclk_en,
  output logic              wake_irq,
  output logic              cfg_we,
  output logic [CFG_W-1:0]  cfg_wdata
);
  logic ack_s, rx_s, ack_q, wake_pulse;
  logic stop_q, wake_en, auto_wake, irq_en, hw_ovr, wake_flag;

  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst(rst), .d(stop_ack), .q(ack_s));
  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      hclk_en <= 1'b1;
      cclk_en <= 1'b1;
    end else begin
      ack_q   <= ack_s;
      hclk_en <= ~ack_s;
      cclk_en <= ~ack_s;
    end
  end

  cs_wake_detect u_wake (
    .clk(clk), .rst(rst), .rx_s(rx_s), .ack_s(ack_s),
    .wake_en(wake_en), .stop_q(stop_q), .wake_pulse(wake_pulse));

  cs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_pulse(wake_pulse), .ack_q(ack_q),
    .stop_q(stop_q), .wake_en(wake_en), .auto_wake(auto_wake), .irq_en(irq_en),
    .hw_ovr(hw_ovr), .wake_flag(wake_flag));

  cs_init_clear #(.CFG_W(CFG_W), .INIT_BIT(INIT_BIT)) u_init (
    .clk(clk), .rst(rst), .arm(wake_pulse && auto_wake && wake_en),
    .ack_q(ack_q), .cfg_rdata(cfg_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata));

  assign stop_req = stop_q;
  assign wake_irq = wake_flag & irq_en;

  assert_cfg_we_clocks_on_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (hclk_en && cclk_en));
endmodule

// File: tb/clkstop_wake_ctrl_tb.sv
module clkstop_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic stop_ack = 1'b0;
  logic rx_in = 1'b1;
  logic [7:0] cfg_rdata = 8'h5B;
  logic stop_req, hclk_en, cclk_en, wake_irq, cfg_we;
  logic [7:0] cfg_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int we_seen = 0;
  logic [7:0] we_data = '0;

  always #2.5 clk = ~clk;

  clkstop_wake_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stop_ack(stop_ack), .rx_in(rx_in),
    .cfg_rdata(cfg_rdata), .stop_req(stop_req), .hclk_en(hclk_en), .cclk_en(cclk_en),
    .wake_irq(wake_irq), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata));

  // behavioural reference: histories of the async inputs and the register state
  logic ack_h[$];
  logic rx_h[$];
  logic m_stop, m_ovr, m_flag, m_wen, m_aut, m_ien, m_pend, m_we, m_wp, m_ackd_prev;
  logic [7:0] m_wd;

  function automatic logic ack_at(int n); return ack_h[n]; endfunction

  always @(posedge clk) begin
    if (rst) begin
      ack_h = {1'b0, 1'b0, 1'b0, 1'b0};
      rx_h  = {1'b1, 1'b1, 1'b1};
      m_stop = 0; m_ovr = 0; m_flag = 0; m_wen = 0; m_aut = 0; m_ien = 0;
      m_pend = 0; m_we = 0; m_wp = 0; m_wd = 0; m_ackd_prev = 0;
    end else begin
      logic fall, n_wp, n_we, ackd;
      // ack_h[0]=1 edge ago, [1]=2 edges (synced), [2]=3 edges (registered)
      fall = rx_h[2] && !rx_h[1] && ack_h[1] && m_wen && m_stop;
      n_wp = fall;
      ackd = ack_h[2];
      n_we = m_pend && m_ackd_prev && !ackd;
      if (n_we) begin m_wd = cfg_rdata & 8'hFE; m_pend = 0; end
      if (m_wp && m_aut && m_wen) m_pend = 1;
      if (wr_en && wr_addr == 2'd0) begin
        m_wen = wr_data[0]; m_aut = wr_data[1]; m_ien = wr_data[2];
      end
      if (m_wp) begin
        m_stop = 0; m_ovr = 1; m_flag = 1;
      end else begin
        if (wr_en && wr_addr == 2'd1) begin
          m_stop = wr_data[0];
          if (wr_data[0]) m_ovr = 0;
        end
        if (wr_en && wr_addr == 2'd2 && wr_data[2]) m_flag = 0;
      end
      m_ackd_prev = ackd;
      m_wp = n_wp;
      m_we = n_we;
      ack_h.push_front(stop_ack); void'(ack_h.pop_back());
      rx_h.push_front(rx_in); void'(rx_h.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_ien, m_aut, m_wen};
      2'd1: return {7'b0, m_stop};
      2'd2: return {5'b0, m_flag, m_ovr, ack_h[2]};
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      check("R1 stop_req", {7'b0, stop_req}, {7'b0, m_stop});
      check("R2 hclk_en", {7'b0, hclk_en}, {7'b0, !ack_h[2]});
      check("R2 cclk_en", {7'b0, cclk_en}, {7'b0, !ack_h[2]});
      check("R6 wake_irq", {7'b0, wake_irq}, {7'b0, m_flag && m_ien});
      check("R7 cfg_we", {7'b0, cfg_we}, {7'b0, m_we});
      if (m_we) check("R7 cfg_wdata", cfg_wdata, m_wd);
      check("R10 rd_data", rd_data, model_rd(rd_addr));
      if (cfg_we) begin we_seen++; we_data = cfg_wdata; end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cycles(int n); repeat (n) @(negedge clk); endtask

  task automatic rd_check(string tag, logic [1:0] a, logic [7:0] exp);
    @(negedge clk); rd_addr = a; #0.5;
    check(tag, rd_data, exp);
  endtask

  task automatic rx_pulse();
    @(negedge clk); rx_in = 0; cycles(4); rx_in = 1; cycles(4);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    cycles(3); rst = 0; cycles(1);
    // reset state
    check("R2 reset hclk_en", {7'b0, hclk_en}, 8'h01);
    check("R1 reset stop_req", {7'b0, stop_req}, 8'h00);
    rd_check("R10 reset status", 2'd2, 8'h00);

    // R1/R3: stop with wake disabled, rx activity ignored
    wr(2'd1, 8'h01);
    check("R1 stop set", {7'b0, stop_req}, 8'h01);
    @(negedge clk); stop_ack = 1; cycles(5);
    check("R2 gated hclk", {7'b0, hclk_en}, 8'h00);
    rx_pulse();
    check("R3 stop kept", {7'b0, stop_req}, 8'h01);
    rd_check("R3 status no ovr", 2'd2, 8'h01);
    wr(2'd1, 8'h00); @(negedge clk); stop_ack = 0; cycles(5);
    check("R2 ungated cclk", {7'b0, cclk_en}, 8'h01);

    // R9: wake enabled, clocks not gated
    wr(2'd0, 8'h05); wr(2'd1, 8'h01);
    rx_pulse();
    check("R9 no wake ungated", {7'b0, stop_req}, 8'h01);

    // R4/R6: wake while gated with interrupt enabled
    @(negedge clk); stop_ack = 1; cycles(5);
    rx_pulse();
    check("R4 stop cleared", {7'b0, stop_req}, 8'h00);
    rd_check("R4 status ovr+flag", 2'd2, 8'h07);
    check("R6 irq high", {7'b0, wake_irq}, 8'h01);
    @(negedge clk); stop_ack = 0; cycles(5);

    // R10: W1C flag
    wr(2'd2, 8'h00);
    check("R10 write 0 keeps", {7'b0, wake_irq}, 8'h01);
    wr(2'd2, 8'h04);
    check("R10 flag cleared", {7'b0, wake_irq}, 8'h00);

    // R5: next stop set clears override
    wr(2'd1, 8'h01);
    rd_check("R5 ovr cleared", 2'd2, 8'h00);

    // R6: interrupt disabled
    wr(2'd0, 8'h01);
    @(negedge clk); stop_ack = 1; cycles(5);
    rx_pulse();
    rd_check("R6 flag set", 2'd2, 8'h07);
    check("R6 irq masked", {7'b0, wake_irq}, 8'h00);
    @(negedge clk); stop_ack = 0; cycles(5);
    wr(2'd2, 8'h04);

    // R7: auto-wake clears init bit by read-modify-write
    wr(2'd0, 8'h03); wr(2'd1, 8'h01);
    @(negedge clk); stop_ack = 1; cycles(5);
    we_seen = 0;
    rx_pulse();
    check("R7 no write while gated", we_seen[7:0], 8'h00);
    @(negedge clk); stop_ack = 0; cycles(6);
    check("R7 one write", we_seen[7:0], 8'h01);
    check("R7 write data", we_data, 8'h5A);

    // R8: stop write collides with wake
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h01); wr(2'd1, 8'h01);
    @(negedge clk); stop_ack = 1; cycles(5);
    @(negedge clk); rx_in = 0;
    cycles(3);
    wr_en = 1; wr_addr = 2'd1; wr_data = 8'h01;
    @(negedge clk); wr_en = 0;
    check("R8 wake wins stop", {7'b0, stop_req}, 8'h00);
    rd_check("R8 ovr kept", 2'd2, 8'h07);
    rx_in = 1;
    @(negedge clk); stop_ack = 0; cycles(6);
    finish_run();
  end
endmodule